// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This block is the last step of a binary64 arithmetic datapath. An upstream operator delivers a sign, a signed unbiased exponent and a 56-bit extended significand. The significand is normalized, with the hidden bit at bit 55. Bits 54 to 3 hold the fraction, and bits 2 to 0 hold the guard, round and sticky information. The unit turns this into a packed 64-bit double and raises the inexact, underflow and overflow flags for that one operation.

Values below the normal range are denormalized by a sticky right shift. Alternatively, when flush-to-zero is enabled, they are replaced by a rounding-mode-dependent flush value. Rounding follows one of four modes, and a carry out of the significand renormalizes the result. Results above the normal range saturate to infinity or to the largest finite value, depending on the mode and the sign. One special case covers an exponent one step below the minimum: when trial rounding carries into bit 56, the value is treated as not tiny.

A single register stage holds the result. A valid/ready handshake connects it to the producer and to the consumer.

Top module: `dp_round_pack`

## Requirements
- R1: When bits 2..0 of the aligned significand are nonzero, rounding is applied by mode, with the encoding 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. Nearest adds 3 plus significand bit 3. Toward zero adds nothing. Toward +infinity adds 8 only when the sign is 0. Toward -infinity adds 8 only when the sign is 1.
- R2: Nonzero bits 2..0 after alignment set the inexact flag (output bit order of flags is separate: inexact, underflow, overflow ports).
- R3: A rounding carry out of bit 55 shifts the significand right by one and increments the exponent. An all-ones significand therefore rounds to the next power of two.
- R4: An exponent below -1022, with flush disabled, shifts the significand right by (-1022 - exponent), with all bits shifted out ORed into bit 0. The exponent becomes -1022. A shift of 56 or more leaves only the sticky bit.
- R5: Underflow is raised when the result is inexact and the hidden bit is clear before rounding. Underflow is also raised when the rounded result is denormal and the underflow-trap enable is set, even if the result is exact.
- R6: At exponent -1023 with flush disabled, if rounding the unshifted significand carries into bit 56, the result is the smallest normal value (exponent field 1, fraction 0). Inexact is set and underflow is not.
- R7: An exponent below -1022 with flush enabled raises underflow and inexact. The result is a signed zero for modes 0 and 1. Mode 2 gives fraction 1 for sign 0 and negative zero for sign 1. Mode 3 gives negative fraction 1 for sign 1 and positive zero for sign 0. Exponents of -1022 and above are unaffected by flush.
- R8: A rounded exponent above 1023 raises overflow and inexact. The result is infinity (0x7FF, fraction 0) for mode 0, and for mode 2 with sign 0 or mode 3 with sign 1. Otherwise the result is the largest finite value (field 0x7FE, all-ones fraction) with the input sign.
- R9: A normal result has bit 63 equal to the sign, bits 62..52 equal to the exponent plus 1023, and bits 51..0 equal to the significand without the hidden bit. A denormal result has exponent field 0.
- R10: The result and flags appear with out_valid one cycle after a transfer on in_valid/in_ready. They are held stable while out_ready is low. in_ready is high when the output register is empty or is being drained.
- R11: After reset, out_valid is low and in_ready is high.
- R12: Flags describe only the operation shown, and nothing carries over from a previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can accept an operand |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed unbiased exponent |
| in_mant | input | 56 | Extended significand, hidden bit at 55 |
| in_rmode | input | 2 | Rounding mode (0 nearest, 1 zero, 2 +inf, 3 -inf) |
| in_ftz | input | 1 | Flush-to-zero enable |
| in_uf_trap | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Packed binary64 result |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
The assertions take for granted that every accepted significand is normalized, with bit 55 set. They also assume the upstream never presents a zero or a NaN, since neither case is modelled. Under that premise, only an overflow can produce an all-ones exponent field, and an underflow can only come with an exponent field of 0 or 1. The stimulus therefore drives only significands with the top bit set. Exponents stay inside the 13-bit signed range, with values chosen on both sides of -1023, -1022, 1023 and 1024, and one value far below the shift width.

// File: rtl/dp_rp_pkg.sv
package dp_rp_pkg;
  localparam int FRAC_W = 52;
  localparam int EXPF_W = 11;
  localparam int XW     = 13;
  localparam int MW     = FRAC_W + 4;
  localparam int SW     = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int EMAX   = BIAS;
  localparam int RW     = 1 + EXPF_W + FRAC_W;

  typedef logic signed [XW:0] sexp_t;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  // Apply the mode-dependent increment; result is one bit wider.
  function automatic logic [MW:0] round_incr(input logic sgn, input logic [MW-1:0] m,
                                             input rmode_e rm);
    logic [MW:0] x;
    x = {1'b0, m};
    if (m[2:0] != 3'b000) begin
      case (rm)
        RM_NEAR: x = x + (MW+1)'(3) + (MW+1)'(m[3]);
        RM_POS:  if (!sgn) x = x + (MW+1)'(8);
        RM_NEG:  if (sgn)  x = x + (MW+1)'(8);
        default: x = x;
      endcase
    end
    return x;
  endfunction

  // Right shift keeping every lost bit as a sticky bit in position 0.
  function automatic logic [MW-1:0] sticky_shr(input logic [MW-1:0] m, input int amt);
    logic [MW-1:0] sh;
    logic [MW-1:0] lost;
    if (amt >= MW) begin
      sh = {{(MW-1){1'b0}}, |m};
    end else begin
      lost = m & ~({MW{1'b1}} << amt);
      sh   = (m >> amt) | {{(MW-1){1'b0}}, |lost};
    end
    return sh;
  endfunction

  // True when mode and sign pick infinity over the largest finite value.
  function automatic logic sat_to_inf(input logic sgn, input rmode_e rm);
    return (rm == RM_NEAR) || (rm == RM_POS && !sgn) || (rm == RM_NEG && sgn);
  endfunction

  // True when mode and sign pick the smallest denormal over zero on flush.
  function automatic logic flush_to_min(input logic sgn, input rmode_e rm);
    return (rm == RM_POS && !sgn) || (rm == RM_NEG && sgn);
  endfunction
endpackage

// File: rtl/dp_rp_align.sv
module dp_rp_align
  import dp_rp_pkg::*;
(
  input  logic                 sgn,
  input  logic signed [XW-1:0] exp_in,
  input  logic [MW-1:0]        mant_in,
  input  rmode_e               rm,
  input  logic                 ftz,
  output logic [MW-1:0]        mant_a,
  output sexp_t                exp_a,
  output logic                 flush_evt,
  output logic [RW-1:0]        flush_res,
  output logic                 nottiny_evt
);
  sexp_t       e_ext;
  logic        below;
  int          shamt;
  logic [MW:0] trial;

  always_comb begin
    e_ext       = sexp_t'(exp_in);
    below       = e_ext < sexp_t'(EMIN);
    shamt       = EMIN - int'(e_ext);
    trial       = round_incr(sgn, mant_in, rm);
    flush_evt   = below && ftz;
    nottiny_evt = below && !ftz && (e_ext == sexp_t'(EMIN - 1)) && trial[MW];
    flush_res   = {sgn, {(RW-2){1'b0}}, flush_to_min(sgn, rm)};
    mant_a      = mant_in;
    exp_a       = e_ext;
    if (nottiny_evt) begin
      mant_a = trial[MW:1] & ~{{(MW-3){1'b0}}, 3'b111};
      exp_a  = sexp_t'(EMIN);
    end else if (below) begin
      mant_a = sticky_shr(mant_in, shamt);
      exp_a  = sexp_t'(EMIN);
    end
  end
endmodule

// File: rtl/dp_rp_round.sv
module dp_rp_round
  import dp_rp_pkg::*;
(
  input  logic          sgn,
  input  logic [MW-1:0] mant_a,
  input  sexp_t         exp_a,
  input  rmode_e        rm,
  output logic [SW-1:0] sig_r,
  output sexp_t         exp_r,
  output logic          rnd_inexact,
  output logic          tiny_uf
);
  logic [MW:0] sum;

  always_comb begin
    sum         = round_incr(sgn, mant_a, rm);
    rnd_inexact = mant_a[2:0] != 3'b000;
    tiny_uf     = rnd_inexact && !mant_a[MW-1];
    if (sum[MW]) begin
      sig_r = sum[MW:4];
      exp_r = exp_a + sexp_t'(1);
    end else begin
      sig_r = sum[MW-1:3];
      exp_r = exp_a;
    end
  end
endmodule

// File: rtl/dp_rp_pack.sv
module dp_rp_pack
  import dp_rp_pkg::*;
(
  input  logic          sgn,
  input  logic [SW-1:0] sig_r,
  input  sexp_t         exp_r,
  input  rmode_e        rm,
  input  logic          uf_trap,
  output logic [RW-1:0] packed_res,
  output logic          ovf_evt,
  output logic          denorm_uf
);
  localparam logic [EXPF_W-1:0] EF_INF = '1;
  localparam logic [EXPF_W-1:0] EF_MAX = EF_INF - 1'b1;

  logic [EXPF_W-1:0] ef;

  always_comb begin
    ovf_evt   = exp_r > sexp_t'(EMAX);
    ef        = EXPF_W'(exp_r + sexp_t'(BIAS));
    denorm_uf = 1'b0;
    if (ovf_evt) begin
      if (sat_to_inf(sgn, rm)) packed_res = {sgn, EF_INF, {FRAC_W{1'b0}}};
      else                     packed_res = {sgn, EF_MAX, {FRAC_W{1'b1}}};
    end else if (!sig_r[SW-1]) begin
      packed_res = {sgn, {EXPF_W{1'b0}}, sig_r[FRAC_W-1:0]};
      denorm_uf  = uf_trap;
    end else begin
      packed_res = {sgn, ef, sig_r[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
  import dp_rp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sign,
  input  logic signed [12:0]   in_exp,
  input  logic [55:0]          in_mant,
  input  logic [1:0]           in_rmode,
  input  logic                 in_ftz,
  input  logic                 in_uf_trap,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [63:0]          out_result,
  output logic                 out_inexact,
  output logic                 out_underflow,
  output logic                 out_overflow
);
  rmode_e        rm;
  logic [MW-1:0] mant_a;
  sexp_t         exp_a;
  logic          flush_evt;
  logic [RW-1:0] flush_res;
  logic          nottiny_evt;
  logic [SW-1:0] sig_r;
  sexp_t         exp_r;
  logic          rnd_inexact;
  logic          tiny_uf;
  logic [RW-1:0] packed_res;
  logic          ovf_evt;
  logic          denorm_uf;
  logic          fire;
  logic [RW-1:0] nxt_res;
  logic          nxt_inx;
  logic          nxt_uf;
  logic          nxt_ovf;

  assign rm       = rmode_e'(in_rmode);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  dp_rp_align u_align (
    .sgn(in_sign), .exp_in(in_exp), .mant_in(in_mant), .rm(rm), .ftz(in_ftz),
    .mant_a(mant_a), .exp_a(exp_a), .flush_evt(flush_evt), .flush_res(flush_res),
    .nottiny_evt(nottiny_evt)
  );

  dp_rp_round u_round (
    .sgn(in_sign), .mant_a(mant_a), .exp_a(exp_a), .rm(rm),
    .sig_r(sig_r), .exp_r(exp_r), .rnd_inexact(rnd_inexact), .tiny_uf(tiny_uf)
  );

  dp_rp_pack u_pack (
    .sgn(in_sign), .sig_r(sig_r), .exp_r(exp_r), .rm(rm), .uf_trap(in_uf_trap),
    .packed_res(packed_res), .ovf_evt(ovf_evt), .denorm_uf(denorm_uf)
  );

  always_comb begin
    if (flush_evt) begin
      nxt_res = flush_res;
      nxt_inx = 1'b1;
      nxt_uf  = 1'b1;
      nxt_ovf = 1'b0;
    end else begin
      nxt_res = packed_res;
      nxt_inx = nottiny_evt || rnd_inexact || ovf_evt;
      nxt_uf  = tiny_uf || denorm_uf;
      nxt_ovf = ovf_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_inexact   <= 1'b0;
      out_underflow <= 1'b0;
      out_overflow  <= 1'b0;
    end else if (fire) begin
      out_valid     <= 1'b1;
      out_result    <= nxt_res;
      out_inexact   <= nxt_inx;
      out_underflow <= nxt_uf;
      out_overflow  <= nxt_ovf;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/dp_round_pack_chk.sv
module dp_round_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fire,
  input logic        flush_evt,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_inexact,
  input logic        out_underflow,
  input logic        out_overflow
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
    $stable({out_inexact, out_underflow, out_overflow}));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R8
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact);

  // R8
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |->
      (out_result[62:0] == {11'h7FF, 52'h0}) || (out_result[62:0] == {11'h7FE, {52{1'b1}}}));

  // R9
  no_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_result[62:52] == 11'h7FF |-> out_overflow && out_result[51:0] == 52'h0);

  // R5
  uf_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_result[62:52] <= 11'd1 && !out_overflow);

  // R7
  flush_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && flush_evt |=> out_underflow && out_inexact && out_result[62:1] == 62'h0);
endmodule

bind dp_round_pack dp_round_pack_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fire(fire), .flush_evt(flush_evt),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_inexact(out_inexact), .out_underflow(out_underflow), .out_overflow(out_overflow)
);

// File: tb/dp_round_pack_tb_top.sv
module dp_round_pack_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic               in_sign = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [55:0]        in_mant = '0;
  logic [1:0]         in_rmode = '0;
  logic               in_ftz = 1'b0;
  logic               in_uf_trap = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [63:0]        out_result;
  logic               out_inexact;
  logic               out_underflow;
  logic               out_overflow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_round_pack dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_rmode(in_rmode),
    .in_ftz(in_ftz), .in_uf_trap(in_uf_trap), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_inexact(out_inexact),
    .out_underflow(out_underflow), .out_overflow(out_overflow)
  );

  localparam logic V_SGN [NV] = '{0,0,0,0,0,1,1,0,0,1,1,0,0,0,0,0,0,0,1,0,1,1,0,0,1,0};
  localparam logic signed [12:0] V_EXP [NV] = '{
    13'sd0, 13'sd0, 13'sd0, 13'sd0, 13'sd0, 13'sd0, 13'sd0, 13'sd0,
    13'sd1024, 13'sd1024, 13'sd1024, 13'sd1023,
    -13'sd1023, -13'sd1023, -13'sd1024, -13'sd1024, -13'sd1023, -13'sd1023,
    -13'sd1023, -13'sd1023, -13'sd1023, -13'sd1023, -13'sd4000, -13'sd1022,
    13'sd1024, 13'sd1024};
  localparam logic [55:0] V_MANT [NV] = '{
    56'h80000000000000, 56'h80000000000004, 56'h8000000000000C, 56'h8000000000000F,
    56'h80000000000001, 56'h80000000000001, 56'h80000000000001, 56'hFFFFFFFFFFFFFF,
    56'h80000000000000, 56'h80000000000000, 56'h80000000000000, 56'hFFFFFFFFFFFFFF,
    56'h80000000000000, 56'h80000000000000, 56'h80000000000004, 56'h80000000000002,
    56'hFFFFFFFFFFFFFF, 56'hFFFFFFFFFFFFFF, 56'h80000000000000, 56'h80000000000000,
    56'h80000000000000, 56'h80000000000000, 56'h80000000000000, 56'h80000000000000,
    56'h80000000000000, 56'h80000000000000};
  localparam logic [1:0] V_RM [NV] = '{0,0,0,1,2,2,3,0,0,1,3,0,1,1,0,2,0,1,0,2,3,2,2,0,2,2};
  localparam logic V_FTZ [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,1,1,1,0,1,0,0};
  localparam logic V_UFT [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,0,0,0,0,0,0,0,0,0};
  localparam logic [63:0] V_RES [NV] = '{
    64'h3FF0000000000000, 64'h3FF0000000000000, 64'h3FF0000000000002, 64'h3FF0000000000001,
    64'h3FF0000000000001, 64'hBFF0000000000000, 64'hBFF0000000000001, 64'h4000000000000000,
    64'h7FF0000000000000, 64'hFFEFFFFFFFFFFFFF, 64'hFFF0000000000000, 64'h7FF0000000000000,
    64'h0008000000000000, 64'h0008000000000000, 64'h0004000000000000, 64'h0004000000000001,
    64'h0010000000000000, 64'h000FFFFFFFFFFFFF, 64'h8000000000000000, 64'h0000000000000001,
    64'h8000000000000001, 64'h8000000000000000, 64'h0000000000000001, 64'h0010000000000000,
    64'hFFEFFFFFFFFFFFFF, 64'h7FF0000000000000};
  // flags as {inexact, underflow, overflow}
  localparam logic [2:0] V_FLG [NV] = '{
    3'b000, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100,
    3'b101, 3'b101, 3'b101, 3'b101, 3'b000, 3'b010, 3'b110, 3'b110,
    3'b100, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b000,
    3'b101, 3'b101};
  localparam string V_REQ [NV] = '{
    "R9", "R1,R2", "R1", "R1", "R1", "R1", "R1", "R3",
    "R8", "R8,R9", "R8", "R3,R8", "R4", "R5", "R5", "R4",
    "R6", "R6", "R7", "R7", "R7", "R7", "R4", "R7",
    "R8", "R8,R12"};

  task automatic check_val(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic report_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic drive(input logic s, input logic signed [12:0] e, input logic [55:0] m,
                       input logic [1:0] r, input logic f, input logic u);
    in_sign = s; in_exp = e; in_mant = m; in_rmode = r; in_ftz = f; in_uf_trap = u;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_end();
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check_val("R11 out_valid", 64'(out_valid), 64'd0);
    check_val("R11 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R11 idle", 64'(out_valid), 64'd0);

    // vector table, one operation per cycle pair
    for (int i = 0; i < NV; i++) begin
      drive(V_SGN[i], V_EXP[i], V_MANT[i], V_RM[i], V_FTZ[i], V_UFT[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check_val({V_REQ[i], " valid"}, 64'(out_valid), 64'd1);
      check_val({V_REQ[i], " result"}, out_result, V_RES[i]);
      check_val({V_REQ[i], " flags"}, 64'({out_inexact, out_underflow, out_overflow}),
                64'(V_FLG[i]));
    end

    // R12 a clean operation right after an overflow shows no flags
    drive(1'b0, 13'sd5, 56'h80000000000000, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check_val("R12 flags", 64'({out_inexact, out_underflow, out_overflow}), 64'd0);
    check_val("R12 result", out_result, 64'h4040000000000000);
    @(negedge clk);
    check_val("R10 drain", 64'(out_valid), 64'd0);

    // R10 backpressure
    out_ready = 1'b0;
    drive(1'b0, 13'sd0, 56'h80000000000000, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    check_val("R10 valid", 64'(out_valid), 64'd1);
    check_val("R10 stall ready", 64'(in_ready), 64'd0);
    drive(1'b0, 13'sd1024, 56'h80000000000000, 2'd0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check_val("R10 held result", out_result, 64'h3FF0000000000000);
    check_val("R10 held flags", 64'(out_overflow), 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_val("R10 next result", out_result, 64'h7FF0000000000000);
    check_val("R10 next valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    check_val("R10 empty", 64'(out_valid), 64'd0);

    report_end();
  end
endmodule